// File: doc/BRIEF.md
# Serial-Loaded Wiper Register Controller

This block is the digital half of a 128-step potentiometer. A host loads a new wiper position over a three-wire serial link: an active-low select, a serial clock and a data line. Bits enter a 7-bit shift register most significant bit first. When the select line returns high, the register contents are copied into the wiper latch. The latch drives the 7-bit wiper code that selects a tap on the resistor ladder. A serial data output repeats each bit seven serial clocks after it entered, so several devices can share one link in a chain.

Two active-low controls act apart from the serial port. The preset input forces the wiper latch to midscale (0x40) and clears the serial-output bit. The shutdown input opens the terminal-A switch, ties the wiper to terminal B and turns off the serial-output driver. While shutdown is active the stored code is kept and can still be overwritten. All pins are taken into a fast system clock domain through synchronizer chains, and the serial edges are detected in that domain.

Top module: `pot_serial_ctrl`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` shifts the `sdi` level into the shift register, and the first bit received ends up as the most significant bit of the code.
- R2: A rising edge of `cs_n` copies the 7-bit shift register into `wiper_code` when `preset_n` is high.
- R3: If more than 7 bits are clocked in during one select window, only the last 7 bits received reach `wiper_code`; the earlier ones are dropped.
- R4: After each shift, `sdo` carries the bit that entered seven shifts earlier.
- R5: While `preset_n` is low, `wiper_code` is 0x40 and `sdo` is 0. This holds even when a `cs_n` rising edge arrives in the same cycle.
- R6: While `cs_n` is high, `sclk` edges change neither the shift register nor `sdo`, and `wiper_code` holds its value.
- R7: While `shdn_n` is low, `term_a_closed` is 0, `wiper_to_b` is 1 and `sdo_oe` is 0, and `wiper_code` keeps its stored value.
- R8: Serial writes made during shutdown update `wiper_code`. Once `shdn_n` is released, `term_a_closed` returns to 1 and `wiper_to_b` returns to 0, and the written code remains in place.
- R9: `sdo_oe` is 1 only while `cs_n` is low and `shdn_n` is high.
- R10: The system reset `rst_n` sets `wiper_code` to 0x40, clears `sdo` and the shift register, and releases shutdown and select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous active-low system reset |
| cs_n | input | 1 | Active-low serial select; its rising edge commits the code |
| sclk | input | 1 | Serial clock; shifts on its rising edge |
| sdi | input | 1 | Serial data in, most significant bit first |
| preset_n | input | 1 | Active-low midscale preset |
| shdn_n | input | 1 | Active-low shutdown |
| wiper_code | output | 7 | Latched wiper position |
| term_a_closed | output | 1 | 1 when the terminal-A switch is closed |
| wiper_to_b | output | 1 | 1 when the wiper is shorted to terminal B |
| sdo | output | 1 | Serial data out for chaining |
| sdo_oe | output | 1 | Output enable of the serial data out driver |

## Verification
The bench uses the default 7-bit code width and two synchronizer stages. With only 128 codes, it can write every code value and read each one back. It also checks every shift against a history of all bits sent, so the seven-shift delay is covered both across word boundaries and inside overlong words. The small width also makes the directed cases short. These cases are preset arriving together with a commit, clocking while deselected, and writes during shutdown.

// File: rtl/pot_pkg.sv
// Package: shared pin bundle type and its idle value for the wiper controller.
// Assumes: all pins are single-bit, active levels as named.
package pot_pkg;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
        logic preset_n;
        logic shdn_n;
    } pot_pins_t;

    localparam int unsigned PINS_W = $bits(pot_pins_t);

    // Pin levels seen when nothing is driving activity.
    localparam pot_pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0,
                                        preset_n: 1'b1, shdn_n: 1'b1};

endpackage

// File: rtl/pot_sync.sv
// Module: multi-bit synchronizer chain.
// Does: passes an asynchronous bundle through STAGES flops into the clk domain.
// Assumes: each bit is independent; STAGES >= 1; reset loads RST_VAL.
module pot_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One stage of the chain: first stage takes the pin, others the previous stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[s] <= RST_VAL;
            end else if (s == 0) begin
                chain[s] <= d;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pot_edge.sv
// Module: rising-edge detector.
// Does: emits a one-cycle pulse when a synchronized level goes from 0 to 1.
// Assumes: input is already in the clk domain.
module pot_edge #(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= RST_LEVEL;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;

endmodule

// File: rtl/pot_shifter.sv
// Module: serial input shift register with delayed serial output latch.
// Does: shifts MSB-first on shift_en; the bit leaving the top lands in sdo_q.
// Assumes: clr_out has priority over a shift for the output latch only.
module pot_shifter #(
    parameter int unsigned CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    input  logic              clr_out,
    output logic [CODE_W-1:0] word,
    output logic              sdo_q
);

    logic [CODE_W-1:0] sr;

    // Shift register: new bit enters at the bottom, oldest leaves at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[CODE_W-2:0], din};
    end

    // Output latch: takes the bit shifted out, cleared by preset.
    always_ff @(posedge clk) begin
        if (!rst_n)        sdo_q <= 1'b0;
        else if (clr_out)  sdo_q <= 1'b0;
        else if (shift_en) sdo_q <= sr[CODE_W-1];
    end

    assign word = sr;

endmodule

// File: rtl/pot_wiper_latch.sv
// Module: wiper code latch.
// Does: holds the active code; preset forces midscale and beats a load.
// Assumes: load and preset are single-cycle or level signals in the clk domain.
module pot_wiper_latch #(
    parameter int unsigned CODE_W = 7,
    localparam logic [CODE_W-1:0] MID = 1 << (CODE_W-1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              preset,
    input  logic [CODE_W-1:0] load_val,
    output logic [CODE_W-1:0] code
);

    // Code register: reset and preset give midscale, load takes the new word.
    always_ff @(posedge clk) begin
        if (!rst_n)      code <= MID;
        else if (preset) code <= MID;
        else if (load)   code <= load_val;
    end

endmodule

// File: rtl/pot_serial_ctrl.sv
// Module: serial-loaded wiper register controller (top).
// Does: synchronizes the serial pins, shifts data while selected, commits on
//       select release, and drives switch controls for shutdown.
// Assumes: clk is several times faster than sclk so every pin level lasts
//          at least SYNC_STAGES+2 clk cycles.
module pot_serial_ctrl #(
    parameter int unsigned CODE_W      = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              preset_n,
    input  logic              shdn_n,
    output logic [CODE_W-1:0] wiper_code,
    output logic              term_a_closed,
    output logic              wiper_to_b,
    output logic              sdo,
    output logic              sdo_oe
);
    import pot_pkg::*;

    pot_pins_t pins_raw;
    pot_pins_t pins_s;
    logic [PINS_W-1:0] pins_s_bits;

    logic cs_s, sclk_s, sdi_s, preset_s, shdn_s;
    logic sclk_rise, cs_rise, shift_en, commit;
    logic [CODE_W-1:0] sr_word;
    logic sdo_q;

    // Gather pins into one bundle for the synchronizer.
    always_comb begin
        pins_raw.cs_n     = cs_n;
        pins_raw.sclk     = sclk;
        pins_raw.sdi      = sdi;
        pins_raw.preset_n = preset_n;
        pins_raw.shdn_n   = shdn_n;
    end

    pot_sync #(
        .W      (PINS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s_bits)
    );

    assign pins_s   = pot_pins_t'(pins_s_bits);
    assign cs_s     = pins_s.cs_n;
    assign sclk_s   = pins_s.sclk;
    assign sdi_s    = pins_s.sdi;
    assign preset_s = pins_s.preset_n;
    assign shdn_s   = pins_s.shdn_n;

    pot_edge #(.RST_LEVEL(1'b0)) u_sclk_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(sclk_s),
        .rise (sclk_rise)
    );

    pot_edge #(.RST_LEVEL(1'b1)) u_cs_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(cs_s),
        .rise (cs_rise)
    );

    assign shift_en = sclk_rise & ~cs_s;
    assign commit   = cs_rise;

    pot_shifter #(.CODE_W(CODE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .din     (sdi_s),
        .clr_out (~preset_s),
        .word    (sr_word),
        .sdo_q   (sdo_q)
    );

    pot_wiper_latch #(.CODE_W(CODE_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (commit),
        .preset  (~preset_s),
        .load_val(sr_word),
        .code    (wiper_code)
    );

    // Switch controls and output driver enable follow the synchronized levels.
    always_comb begin
        term_a_closed = shdn_s;
        wiper_to_b    = ~shdn_s;
        sdo_oe        = ~cs_s & shdn_s;
        sdo           = sdo_q;
    end

endmodule

// File: rtl/pot_serial_ctrl_chk.sv
// Module: property checker for pot_serial_ctrl, attached with bind.
// Does: checks latch, preset, shutdown and driver-enable rules over time.
// Assumes: connected to the top's synchronized internal levels.
module pot_serial_ctrl_chk #(
    parameter int unsigned CODE_W = 7,
    localparam logic [CODE_W-1:0] MID = 1 << (CODE_W-1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              preset_s,
    input logic              shdn_s,
    input logic              cs_s,
    input logic              shift_en,
    input logic [CODE_W-1:0] sr_word,
    input logic [CODE_W-1:0] wiper_code,
    input logic              term_a_closed,
    input logic              wiper_to_b,
    input logic              sdo,
    input logic              sdo_oe
);

    p_commit_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && preset_s) |=> (wiper_code == $past(sr_word)));

    p_preset_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_s |=> (wiper_code == MID && sdo == 1'b0));

    p_hold_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && preset_s) |=> $stable(wiper_code));

    p_sdo_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && preset_s) |=> $stable(sdo));

    p_shdn_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_s |-> (!term_a_closed && wiper_to_b && !sdo_oe));

    p_oe_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !sdo_oe);

endmodule

bind pot_serial_ctrl pot_serial_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit       (commit),
    .preset_s     (preset_s),
    .shdn_s       (shdn_s),
    .cs_s         (cs_s),
    .shift_en     (shift_en),
    .sr_word      (sr_word),
    .wiper_code   (wiper_code),
    .term_a_closed(term_a_closed),
    .wiper_to_b   (wiper_to_b),
    .sdo          (sdo),
    .sdo_oe       (sdo_oe)
);

// File: tb/pot_serial_ctrl_test.sv
`timescale 1ns/1ps
// Bench: sweeps all codes, tracks every shifted bit for the delayed output,
// and runs directed preset, deselect and shutdown cases.
module pot_serial_ctrl_test;

    localparam int unsigned CODE_W = 7;
    localparam int unsigned SETTLE = 6;
    localparam logic [CODE_W-1:0] MID = 7'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic preset_n = 1'b1;
    logic shdn_n = 1'b1;
    logic [CODE_W-1:0] wiper_code;
    logic term_a_closed, wiper_to_b, sdo, sdo_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit hist[$];

    always #2 clk = ~clk;

    pot_serial_ctrl #(.CODE_W(CODE_W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .preset_n(preset_n), .shdn_n(shdn_n), .wiper_code(wiper_code),
        .term_a_closed(term_a_closed), .wiper_to_b(wiper_to_b),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        #1;
    endtask

    // One serial bit: data set with sclk low, then sclk rises.
    task automatic send_bit(input bit b);
        sclk = 1'b0;
        sdi  = b;
        settle();
        sclk = 1'b1;
        settle();
        if (!cs_n) begin
            hist.push_back(b);
            if (sdo_oe)
                check(sdo == hist[hist.size()-8], "R4", sdo, hist[hist.size()-8]);
        end
    endtask

    task automatic write_word(input int nbits, input logic [31:0] val);
        cs_n = 1'b0;
        settle();
        for (int i = nbits-1; i >= 0; i--) send_bit(val[i]);
        sclk = 1'b0;
        settle();
        cs_n = 1'b1;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) hist.push_back(1'b0);
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        settle();
        // R10: reset state
        check(wiper_code == MID, "R10", wiper_code, MID);
        check(sdo == 1'b0, "R10", sdo, 0);
        check(sdo_oe == 1'b0, "R9", sdo_oe, 0);
        check(term_a_closed == 1'b1 && wiper_to_b == 1'b0, "R10",
              {term_a_closed, wiper_to_b}, 2'b10);

        // R1 R2: every code, MSB first
        for (int v = 0; v < 128; v++) begin
            write_word(7, v);
            check(wiper_code == v[6:0], "R1 R2", wiper_code, v);
        end

        // R9: driver enabled only while selected
        cs_n = 1'b0;
        settle();
        check(sdo_oe == 1'b1, "R9", sdo_oe, 1);
        cs_n = 1'b1;
        settle();
        check(sdo_oe == 1'b0, "R9", sdo_oe, 0);

        // R3: overlong words keep the last 7 bits
        write_word(10, 32'h3AB);
        check(wiper_code == 7'h2B, "R3", wiper_code, 7'h2B);
        write_word(14, 32'h2F55);
        check(wiper_code == 7'h55, "R3", wiper_code, 7'h55);

        // R6: clocking while deselected changes nothing
        write_word(7, 32'h15);
        begin
            logic sdo_before;
            sdo_before = sdo;
            for (int i = 0; i < 7; i++) send_bit(1'b1);
            sclk = 1'b0;
            settle();
            check(wiper_code == 7'h15, "R6", wiper_code, 7'h15);
            check(sdo == sdo_before, "R6", sdo, sdo_before);
        end
        write_word(0, 32'h0);
        check(wiper_code == 7'h15, "R6", wiper_code, 7'h15);

        // R5: preset forces midscale and clears sdo
        preset_n = 1'b0;
        settle();
        check(wiper_code == MID, "R5", wiper_code, MID);
        check(sdo == 1'b0, "R5", sdo, 0);
        preset_n = 1'b1;
        settle();
        check(wiper_code == MID, "R5", wiper_code, MID);

        // R5: preset beats a simultaneous commit
        cs_n = 1'b0;
        settle();
        for (int i = 6; i >= 0; i--) send_bit(7'h11 >> i);
        sclk = 1'b0;
        settle();
        cs_n = 1'b1;
        preset_n = 1'b0;
        settle();
        check(wiper_code == MID, "R5", wiper_code, MID);
        preset_n = 1'b1;
        settle();
        check(wiper_code == MID, "R5", wiper_code, MID);

        // R7: shutdown switches, code kept
        write_word(7, 32'h33);
        shdn_n = 1'b0;
        settle();
        check(term_a_closed == 1'b0, "R7", term_a_closed, 0);
        check(wiper_to_b == 1'b1, "R7", wiper_to_b, 1);
        check(wiper_code == 7'h33, "R7", wiper_code, 7'h33);
        cs_n = 1'b0;
        settle();
        check(sdo_oe == 1'b0, "R7", sdo_oe, 0);
        cs_n = 1'b1;
        settle();

        // R8: writes land during shutdown and survive release
        write_word(7, 32'h5A);
        check(wiper_code == 7'h5A, "R8", wiper_code, 7'h5A);
        shdn_n = 1'b1;
        settle();
        check(term_a_closed == 1'b1 && wiper_to_b == 1'b0, "R8",
              {term_a_closed, wiper_to_b}, 2'b10);
        check(wiper_code == 7'h5A, "R8", wiper_code, 7'h5A);

        // R4: delayed output across a fresh word after shutdown
        write_word(7, 32'h6C);
        check(wiper_code == 7'h6C, "R4 R2", wiper_code, 7'h6C);

        // R10: reset mid-operation
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check(wiper_code == MID, "R10", wiper_code, MID);
        check(sdo == 1'b0, "R10", sdo, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule